// File: doc/BRIEF.md
# Page-Mode DRAM Read Controller

This block sits between a simple synchronous read port and an asynchronous page-mode DRAM. A host raises a request with a word address and an optional burst flag. The controller splits the address into a row part and a column part. It drives the row strobe, the column strobe and a shared address bus to the memory, captures the returned word, and hands it back with a one-cycle valid pulse.

After an access the controller leaves the row open. A later request that targets the same row skips row selection entirely and only presents a new column. A request that targets another row first closes the old row with a precharge interval, then opens the new one. A burst returns four words from the aligned group of four that holds the requested column. It starts at the requested word and wraps inside the group, so the first beat costs the full first-access time and the other three cost the shorter column time.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is held low at a clock edge and in the cycle after it, ready is 1, rvalid is 0, ras_n and cas_n are both 1, and no row is considered open.
- R2: The row is the upper ADDR_W-$clog2(PAGE_WORDS) address bits and is driven on dram_addr when ras_n falls. The column is the lower $clog2(PAGE_WORDS) bits and is driven on dram_addr while cas_n is 0. The returned word is the one stored at that row and column.
- R3: With no row open, the first beat's rvalid is high in cycle FIRST_CYC (default 5), counting the cycle after the accepting edge as cycle 1. ras_n falls exactly once for the request.
- R4: With the addressed row already open, the first beat's rvalid is high in cycle NEXT_CYC (default 3), and ras_n does not fall during the request.
- R5: With a different row open, ras_n is 1 for PRE_CYC cycles (default 2), then falls once. The first beat's rvalid is high in cycle PRE_CYC+FIRST_CYC (default 7).
- R6: A request with burst=1 returns exactly four beats. Each beat after the first has its rvalid exactly NEXT_CYC cycles after the previous beat's rvalid. A request with burst=0 returns one beat.
- R7: Burst beat k (k=0..3) reads column {col[C-1:2], col[1:0]+k mod 4}, where C is the column width, in the same row. A burst never leaves its row.
- R8: rvalid is high for exactly one clock per beat, and rdata holds the beat's word in that cycle.
- R9: ready is 0 from the cycle after a request is accepted through the cycle of the last beat, and is 1 again in the following cycle. A request is accepted on a rising edge where req and ready are both 1.
- R10: cas_n is 0 only while ras_n is 0, and cas_n returns to 1 between consecutive beats.
- R11: After a request completes, ras_n stays 0 while the controller is idle, keeping the row open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Read request, accepted when ready is 1 |
| addr | input | ADDR_W | Word address of the request |
| burst | input | 1 | 1 requests four beats, 0 requests one |
| ready | output | 1 | Controller can accept a request |
| rvalid | output | 1 | One-cycle pulse per returned beat |
| rdata | output | DATA_W | Returned word, valid with rvalid |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| dram_addr | output | max(row, column width) | Multiplexed row/column address |
| dram_dq | input | DATA_W | Data from the memory, driven while cas_n is 0 |

## Verification
The bench drives the three page paths in turn: closed after reset, hit on the open row, and switch to another row. It predicts each beat's cycle from its own model of the open row. A controller that forgot the open row, or never invalidated it, would deliver beats two or four cycles off and would show an unexpected or missing row-strobe fall. Bursts start at the first, middle and last word of a group, including the column at the top of a row. A wrong wrap would return words from a neighbouring group or the next row, and the hashed memory contents would show this as a data mismatch. A reset in the middle of the sequence checks that the page state is dropped, and the idle checks after each request catch a controller that closes the row or reopens the port a cycle late.

// File: rtl/fpm_pkg.sv
`timescale 1ns/1ps
// Shared types for the page-mode DRAM read controller.
// Assumes: nothing beyond the sequencer using this state encoding.
package fpm_pkg;

    // Sequencer phases: idle, closing the old row, opening a row, column access.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_ROW  = 2'd2,
        ST_COL  = 2'd3
    } fpm_state_e;

endpackage

// File: rtl/fpm_page_tracker.sv
`timescale 1ns/1ps
// Open-row tracker: remembers which row is currently held open in the DRAM
// and flags whether an incoming row matches it.
// Assumes: load is pulsed once per accepted request; reset closes the page.
module fpm_page_tracker #(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [ROW_W-1:0] row_in,
    output logic             open_valid,
    output logic [ROW_W-1:0] open_row,
    output logic             hit
);

    // Capture the row of each accepted request; reset forgets the page.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_valid <= 1'b0;
            open_row   <= '0;
        end else if (load) begin
            open_valid <= 1'b1;
            open_row   <= row_in;
        end
    end

    // A hit needs an open page whose row equals the requested one.
    always_comb begin
        hit = open_valid && (open_row == row_in);
    end

    // Once a page is open it stays open until reset.
    AST_PAGE_STAYS_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        open_valid |=> open_valid); // R11

endmodule

// File: rtl/fpm_col_gen.sv
`timescale 1ns/1ps
// Column generator: holds the column of the current beat and steps it
// through the aligned group of BEATS words, wrapping inside the group.
// Assumes: BEATS is a power of two, at least 2, and no larger than a page.
module fpm_col_gen #(
    parameter int COL_W = 10,
    parameter int BEATS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [COL_W-1:0] col_in,
    input  logic             advance,
    output logic [COL_W-1:0] col
);

    localparam int GRP_W = $clog2(BEATS);

    logic [COL_W-1:0] col_next;

    generate
        if (COL_W > GRP_W) begin : g_split
            // Step only the low bits; the group base stays fixed.
            always_comb begin
                col_next = {col[COL_W-1:GRP_W], col[GRP_W-1:0] + GRP_W'(1)};
            end

            // A burst step must never leave its aligned group.
            AST_GROUP_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
                (advance && !load) |=> $stable(col[COL_W-1:GRP_W])); // R7
        end else begin : g_whole
            // The page is one group: wrap the whole column.
            always_comb begin
                col_next = col + COL_W'(1);
            end
        end
    endgenerate

    // Load the requested column on acceptance, then step per finished beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col <= '0;
        end else if (load) begin
            col <= col_in;
        end else if (advance) begin
            col <= col_next;
        end
    end

endmodule

// File: rtl/fpm_seq.sv
`timescale 1ns/1ps
// Access sequencer: walks each request through precharge, row open and
// column phases, and decodes the strobes, the capture point and the beat
// valid from its state and phase counter.
// Assumes: NEXT_CYC >= 3, FIRST_CYC > NEXT_CYC, PRE_CYC >= 1, BEATS >= 2.
module fpm_seq
    import fpm_pkg::*;
#(
    parameter int FIRST_CYC = 5,
    parameter int NEXT_CYC  = 3,
    parameter int PRE_CYC   = 2,
    parameter int BEATS     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    input  logic burst,
    input  logic hit,
    input  logic open_valid,
    output logic ready,
    output logic accept,
    output logic sel_col,
    output logic ras_n,
    output logic cas_n,
    output logic capture,
    output logic rvalid,
    output logic advance
);

    localparam int ROW_CYC = FIRST_CYC - NEXT_CYC;
    localparam int MAX_A   = (PRE_CYC > ROW_CYC) ? PRE_CYC : ROW_CYC;
    localparam int MAX_C   = (MAX_A > NEXT_CYC) ? MAX_A : NEXT_CYC;
    localparam int CNT_W   = $clog2(MAX_C + 1);
    localparam int BEAT_W  = $clog2(BEATS);

    fpm_state_e        state;
    logic [CNT_W-1:0]  cnt;
    logic [BEAT_W-1:0] beats_left;
    logic              col_last;

    // Acceptance and phase-end decode.
    always_comb begin
        accept   = req && (state == ST_IDLE);
        col_last = (state == ST_COL) && (cnt == CNT_W'(NEXT_CYC - 1));
    end

    // Phase sequencing with a per-phase cycle counter and beats remaining.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cnt        <= '0;
            beats_left <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        cnt        <= '0;
                        beats_left <= burst ? BEAT_W'(BEATS - 1) : '0;
                        if (hit) begin
                            state <= ST_COL;
                        end else if (open_valid) begin
                            state <= ST_PRE;
                        end else begin
                            state <= ST_ROW;
                        end
                    end
                end
                ST_PRE: begin
                    if (cnt == CNT_W'(PRE_CYC - 1)) begin
                        cnt   <= '0;
                        state <= ST_ROW;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                ST_ROW: begin
                    if (cnt == CNT_W'(ROW_CYC - 1)) begin
                        cnt   <= '0;
                        state <= ST_COL;
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
                default: begin
                    if (col_last) begin
                        cnt <= '0;
                        if (beats_left != '0) begin
                            beats_left <= beats_left - BEAT_W'(1);
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else begin
                        cnt <= cnt + CNT_W'(1);
                    end
                end
            endcase
        end
    end

    // Strobe, address-select and beat decode from the current phase.
    always_comb begin
        ready   = (state == ST_IDLE);
        sel_col = (state == ST_COL) || (state == ST_IDLE);
        case (state)
            ST_PRE:  ras_n = 1'b1;
            ST_IDLE: ras_n = !open_valid;
            default: ras_n = 1'b0;
        endcase
        cas_n   = !((state == ST_COL) && (cnt >= CNT_W'(1)) &&
                    (cnt <= CNT_W'(NEXT_CYC - 2)));
        capture = (state == ST_COL) && (cnt == CNT_W'(NEXT_CYC - 2));
        rvalid  = col_last;
        advance = col_last && (beats_left != '0);
    end

    // A row switch must not reach the row phase without precharge first.
    AST_SWITCH_PRECHARGES: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && open_valid && !hit) |=> ras_n); // R5

    // A page hit keeps the row strobe asserted through the request.
    AST_HIT_KEEPS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && hit) |=> !ras_n); // R4

endmodule

// File: rtl/fpm_dram_ctrl.sv
`timescale 1ns/1ps
// Page-mode DRAM read controller top: splits the host address into row and
// column, keeps the last row open, sequences strobes for single reads and
// four-beat wrapping bursts, and returns each word with a one-cycle valid.
// Assumes: the memory drives dram_dq while cas_n is low, and the parameter
// limits listed in fpm_seq hold; PAGE_WORDS is a power of two.
module fpm_dram_ctrl #(
    parameter int ADDR_W     = 20,
    parameter int DATA_W     = 32,
    parameter int PAGE_WORDS = 1024,
    parameter int FIRST_CYC  = 5,
    parameter int NEXT_CYC   = 3,
    parameter int PRE_CYC    = 2,
    parameter int BEATS      = 4,
    localparam int COL_W     = $clog2(PAGE_WORDS),
    localparam int ROW_W     = ADDR_W - COL_W,
    localparam int DA_W      = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [ADDR_W-1:0] addr,
    input  logic              burst,
    output logic              ready,
    output logic              rvalid,
    output logic [DATA_W-1:0] rdata,
    output logic              ras_n,
    output logic              cas_n,
    output logic [DA_W-1:0]   dram_addr,
    input  logic [DATA_W-1:0] dram_dq
);

    logic [ROW_W-1:0] row_in;
    logic [COL_W-1:0] col_in;
    logic [ROW_W-1:0] open_row;
    logic [COL_W-1:0] col;
    logic             open_valid;
    logic             hit;
    logic             accept;
    logic             sel_col;
    logic             capture;
    logic             advance;

    // Split the host address into its row and column parts.
    always_comb begin
        row_in = addr[ADDR_W-1:COL_W];
        col_in = addr[COL_W-1:0];
    end

    fpm_page_tracker #(
        .ROW_W (ROW_W)
    ) u_page (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .row_in     (row_in),
        .open_valid (open_valid),
        .open_row   (open_row),
        .hit        (hit)
    );

    fpm_col_gen #(
        .COL_W (COL_W),
        .BEATS (BEATS)
    ) u_col (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .col_in  (col_in),
        .advance (advance),
        .col     (col)
    );

    fpm_seq #(
        .FIRST_CYC (FIRST_CYC),
        .NEXT_CYC  (NEXT_CYC),
        .PRE_CYC   (PRE_CYC),
        .BEATS     (BEATS)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .burst      (burst),
        .hit        (hit),
        .open_valid (open_valid),
        .ready      (ready),
        .accept     (accept),
        .sel_col    (sel_col),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .capture    (capture),
        .rvalid     (rvalid),
        .advance    (advance)
    );

    // Drive the row during row phases and the column otherwise.
    always_comb begin
        dram_addr = sel_col ? DA_W'(col) : DA_W'(open_row);
    end

    // Latch the memory word at the end of the strobe-low window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (capture) begin
            rdata <= dram_dq;
        end
    end

    AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n); // R10

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |=> !rvalid); // R8

    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req && ready) |=> !ready); // R9

    AST_NO_VALID_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !rvalid); // R9

    AST_CAS_HIGH_AFTER_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> cas_n); // R10

    AST_ROW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && $past(!ras_n)) |-> $stable(open_row)); // R11

endmodule

// File: tb/fpm_dram_ctrl_tb.sv
`timescale 1ns/1ps
// Scoreboard bench for the page-mode DRAM read controller with a
// behavioural memory whose contents are a hash of the word address.
module fpm_dram_ctrl_tb;

    localparam int ADDR_W = 20;
    localparam int DATA_W = 32;
    localparam int COL_W  = 10;
    localparam int ROW_W  = 10;
    localparam int FIRST  = 5;
    localparam int NEXT   = 3;
    localparam int PRE    = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              burst = 1'b0;
    logic              ready;
    logic              rvalid;
    logic [DATA_W-1:0] rdata;
    logic              ras_n;
    logic              cas_n;
    logic [9:0]        dram_addr;
    logic [DATA_W-1:0] dram_dq;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    fpm_dram_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req(req), .addr(addr), .burst(burst),
        .ready(ready), .rvalid(rvalid), .rdata(rdata), .ras_n(ras_n),
        .cas_n(cas_n), .dram_addr(dram_addr), .dram_dq(dram_dq)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [DATA_W-1:0] word_of(input logic [ADDR_W-1:0] a);
        return (32'(a) * 32'h9E3779B1) ^ 32'hC0FFEE00;
    endfunction

    // Behavioural memory: row latched on the strobe fall, column read live.
    logic [ROW_W-1:0] row_lat = '0;
    logic             ras_prev = 1'b1;
    int               ras_falls = 0;
    int               cas_bad = 0;

    always @(posedge clk) begin
        if (ras_prev && !ras_n) begin
            row_lat   <= dram_addr;
            ras_falls <= ras_falls + 1;
        end
        if (!cas_n && ras_n) cas_bad <= cas_bad + 1;
        ras_prev <= ras_n;
    end

    assign dram_dq = cas_n ? '0 : word_of({row_lat, dram_addr});

    typedef struct {
        logic [DATA_W-1:0] data;
        int                due;
        string             tag;
    } exp_t;

    exp_t q[$];

    logic             m_open = 1'b0;
    logic [ROW_W-1:0] m_row = '0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pop one expected beat per rvalid and compare data and cycle.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && rvalid) begin
                if (q.size() == 0) begin
                    check(1'b0, "R8 unexpected beat", 1, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    total++;
                    if (rdata !== e.data) begin
                        bad++;
                        $display("FAIL R2/R7/R8 %s: data actual=%h expected=%h", e.tag, rdata, e.data);
                    end
                    check(cyc == e.due, {e.tag, " beat cycle"}, cyc, e.due);
                end
            end
            if (q.size() != 0 && cyc > q[0].due) begin
                check(1'b0, {q[0].tag, " beat missing"}, cyc, q[0].due);
                void'(q.pop_front());
            end
        end
    end

    // Driver: issue one read, predict its beats, then check the idle state.
    task automatic do_read(input logic [ADDR_W-1:0] a, input bit b, input string tag);
        int t;
        int lat;
        int falls0;
        int exp_falls;
        logic [ROW_W-1:0] r;
        logic [COL_W-1:0] c;
        r = a[ADDR_W-1:COL_W];
        c = a[COL_W-1:0];
        @(negedge clk);
        while (!ready) @(negedge clk);
        falls0 = ras_falls;
        req = 1'b1; addr = a; burst = b;
        @(negedge clk);
        t = cyc;
        req = 1'b0;
        check(ready == 1'b0, "R9 ready low after accept", int'(ready), 0);
        if (!m_open) begin lat = FIRST; exp_falls = 1; end
        else if (m_row == r) begin lat = NEXT; exp_falls = 0; end
        else begin lat = PRE + FIRST; exp_falls = 1; end
        m_open = 1'b1; m_row = r;
        for (int k = 0; k < (b ? 4 : 1); k++) begin
            exp_t e;
            e.data = word_of({r, c[COL_W-1:2], 2'(c[1:0] + 2'(k))});
            e.due  = t + lat - 1 + NEXT * k;
            e.tag  = tag;
            q.push_back(e);
        end
        forever begin
            @(negedge clk);
            #2;
            if (q.size() == 0) break;
        end
        @(negedge clk);
        #2;
        check(ready == 1'b1, "R9 ready back after last beat", int'(ready), 1);
        check(ras_falls - falls0 == exp_falls, {tag, " row strobe falls"}, ras_falls - falls0, exp_falls);
        check(ras_n == 1'b0, "R11 row held open while idle", int'(ras_n), 0);
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(ready == 1'b1, "R1 ready in reset", int'(ready), 1);
        check(rvalid == 1'b0, "R1 rvalid in reset", int'(rvalid), 0);
        check(ras_n == 1'b1, "R1 ras_n in reset", int'(ras_n), 1);
        check(cas_n == 1'b1, "R1 cas_n in reset", int'(cas_n), 1);
        rst_n = 1'b1;
        m_open = 1'b0;
    endtask

    initial begin
        apply_reset();
        do_read(20'h00123, 1'b0, "R3 closed-page single");
        do_read(20'h00200, 1'b0, "R4 hit single");
        do_read(20'h00201, 1'b0, "R4 hit single again");
        do_read(20'hABCDE, 1'b0, "R5 row switch single");
        do_read(20'hABC01, 1'b1, "R6 R7 hit burst wrap from 1");
        do_read(20'h12346, 1'b1, "R5 R7 switch burst wrap from 2");
        do_read(20'h007FF, 1'b1, "R7 burst at top of row");
        do_read(20'h007FC, 1'b1, "R6 hit burst aligned");
        apply_reset();
        do_read(20'h3F00D, 1'b1, "R3 R6 burst after reset 5-3-3-3");
        do_read(20'h3F00E, 1'b0, "R4 hit after burst");
        check(cas_bad == 0, "R10 cas without ras", cas_bad, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule